// File: doc/BRIEF.md
# Interlocked Two-Mode Selector

This block decides which of two operating modes, A or B, is in force. Operators request a mode with single-cycle command pulses (`cmd_a`, `cmd_b`). A process condition `cond` forces an automatic changeover from A to B. Each mode is held in its own set/reset memory cell. The changeover path reads the registered value of mode A, so the condition acts on the value A had in the previous processing cycle. One clock cycle models one processing cycle.

The hazard this block closes is a same-cycle race. Mode B is active and `cond` is high. A single-cycle `cmd_a` pulse arrives, and then `cmd_a` and `cond` both fall in the same cycle. A naive design ends up with both modes latched. Here a request for A is refused while B is active and `cond` is high, so the two modes can never both be set.

Two sticky monitor flags are built into the block. One latches if both modes are ever active together. The other latches if mode A becomes active without any `cmd_a` since reset. On a correct design both flags stay low for ever.

Top module: `dual_mode_sel`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `mode_a`, `mode_b`, `flag_both` and `flag_spurious` are all 0 the following cycle, and memory cells clear regardless of other inputs.
- R2: `cmd_b` high at an edge gives `mode_b`=1 and `mode_a`=0 after that edge. This holds whatever `cmd_a` and `cond` are, so B has priority when both commands are high.
- R3: `cmd_a`=1, `cmd_b`=0 and `mode_b`=0 at an edge give `mode_a`=1 after that edge.
- R4: `cmd_a`=1, `cmd_b`=0 and `cond`=0 at an edge give `mode_b`=0 (and `mode_a`=1) after that edge.
- R5: `cmd_a`=1, `cmd_b`=0, `mode_b`=1 and `cond`=1 at an edge leave `mode_b`=1 and `mode_a`=0. The request for A is refused.
- R6: With no command, `mode_a`=1 and `cond`=1 at an edge, the outputs become `mode_a`=0 and `mode_b`=1 after that edge. This changeover uses the registered (previous-cycle) A.
- R7: With no command and no changeover, both modes hold their values.
- R8: `mode_a` and `mode_b` are never 1 in the same cycle. This includes the race sequence: B active with `cond`=1, a one-cycle `cmd_a`, then `cmd_a` and `cond` falling together.
- R9: `mode_a` rises only if `cmd_a` was high at some edge since reset.
- R10: `flag_both` and `flag_spurious` are sticky monitor outputs. They latch one cycle after a mutual-exclusion or spurious-A event. On a correct design they stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_a | input | 1 | Operator request for mode A |
| cmd_b | input | 1 | Operator request for mode B |
| cond | input | 1 | Process condition forcing A to B |
| mode_a | output | 1 | Mode A active (registered) |
| mode_b | output | 1 | Mode B active (registered) |
| flag_both | output | 1 | Sticky: both modes were seen active |
| flag_spurious | output | 1 | Sticky: A became active with no prior request |

## Verification
Every mode result is due exactly one edge after the inputs that cause it. The bench drives inputs at the falling edge and advances its own reference model at the next rising edge. It compares the modes one time unit after that rising edge. The monitor flags lag the mode outputs by a further edge, so they are checked continuously and again after the long random run. The race sequence and the both-commands case are driven directly, and the rest of the run is random pulses from a fixed seed.

// File: rtl/dual_mode_pkg.sv
package dual_mode_pkg;
  typedef struct packed {
    logic set_a;
    logic clr_a;
    logic set_b;
    logic clr_b;
  } mode_ctl_t;

  // Set/clear requests for both cells; a clear dominates inside the cell.
  function automatic mode_ctl_t mode_rules(input logic ca, input logic cb,
                                           input logic c, input logic a_prev,
                                           input logic b_now);
    mode_ctl_t r;
    logic over;
    over    = ~ca & ~cb & a_prev & c;
    r.set_a = ~cb & ca & (~b_now | ~c);
    r.clr_a = cb | over;
    r.set_b = cb | over;
    r.clr_b = ~cb & ca & ~c;
    return r;
  endfunction
endpackage

// File: rtl/sr_cell.sv
module sr_cell #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= INIT;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end
endmodule

// File: rtl/mode_monitor.sv
module mode_monitor (
  input  logic clk,
  input  logic rst,
  input  logic cmd_a,
  input  logic mode_a,
  input  logic mode_b,
  output logic flag_both,
  output logic flag_spurious
);
  logic seen_a;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_a        <= 1'b0;
      flag_both     <= 1'b0;
      flag_spurious <= 1'b0;
    end else begin
      seen_a        <= seen_a | cmd_a;
      flag_both     <= flag_both | (mode_a & mode_b);
      flag_spurious <= flag_spurious | (mode_a & ~seen_a);
    end
  end
endmodule

// File: rtl/dual_mode_sel.sv
module dual_mode_sel (
  input  logic clk,
  input  logic rst,
  input  logic cmd_a,
  input  logic cmd_b,
  input  logic cond,
  output logic mode_a,
  output logic mode_b,
  output logic flag_both,
  output logic flag_spurious
);
  import dual_mode_pkg::*;

  mode_ctl_t ctl;
  logic      a_dly;

  // The registered A is the one-cycle-delayed value used by the changeover.
  assign a_dly = mode_a;
  assign ctl   = mode_rules(cmd_a, cmd_b, cond, a_dly, mode_b);

  sr_cell u_cell_a (.clk(clk), .rst(rst), .set_i(ctl.set_a), .clr_i(ctl.clr_a), .q(mode_a));
  sr_cell u_cell_b (.clk(clk), .rst(rst), .set_i(ctl.set_b), .clr_i(ctl.clr_b), .q(mode_b));

  mode_monitor u_mon (
    .clk(clk), .rst(rst), .cmd_a(cmd_a), .mode_a(mode_a), .mode_b(mode_b),
    .flag_both(flag_both), .flag_spurious(flag_spurious)
  );
endmodule

module dual_mode_sel_chk (
  input logic clk,
  input logic rst,
  input logic cmd_a,
  input logic cmd_b,
  input logic cond,
  input logic mode_a,
  input logic mode_b,
  input logic flag_both,
  input logic flag_spurious
);
  logic asked_a;
  always_ff @(posedge clk) begin
    if (rst) asked_a <= 1'b0;
    else     asked_a <= asked_a | cmd_a;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> !mode_a && !mode_b && !flag_both && !flag_spurious);
  // R2
  b_priority_chk: assert property (@(posedge clk) disable iff (rst) cmd_b |=> mode_b && !mode_a);
  // R3
  a_select_chk: assert property (@(posedge clk) disable iff (rst) cmd_a && !cmd_b && !mode_b |=> mode_a);
  // R4
  a_clears_b_chk: assert property (@(posedge clk) disable iff (rst) cmd_a && !cmd_b && !cond |=> !mode_b && mode_a);
  // R5
  a_refused_chk: assert property (@(posedge clk) disable iff (rst) cmd_a && !cmd_b && mode_b && cond |=> mode_b && !mode_a);
  // R6
  changeover_chk: assert property (@(posedge clk) disable iff (rst) !cmd_a && !cmd_b && mode_a && cond |=> mode_b && !mode_a);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst) !cmd_a && !cmd_b && !(mode_a && cond) |=> $stable(mode_a) && $stable(mode_b));
  // R8
  exclusive_chk: assert property (@(posedge clk) disable iff (rst) !(mode_a && mode_b));
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst) $rose(mode_a) |-> asked_a);
  // R10
  flags_low_chk: assert property (@(posedge clk) disable iff (rst) !flag_both && !flag_spurious);
endmodule

bind dual_mode_sel dual_mode_sel_chk u_chk (.*);

// File: tb/dual_mode_sel_tb.sv
module dual_mode_sel_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_a = 1'b0, cmd_b = 1'b0, cond = 1'b0;
  logic mode_a, mode_b, flag_both, flag_spurious;
  int total = 0, bad = 0;
  logic ea = 1'b0, eb = 1'b0;

  always #2.5 clk = ~clk;

  dual_mode_sel u_dut (.*);

  // Reference next state, written as a case table on the inputs.
  function automatic logic [1:0] ref_next(logic a, logic b, logic ca, logic cb, logic c);
    case ({cb, ca})
      2'b10, 2'b11: return 2'b01;
      2'b01: begin
        if (b && c) return {a, b};
        return 2'b10;
      end
      default: begin
        if (a && c) return 2'b01;
        return {a, b};
      end
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic ca, logic cb, logic c, string req);
    logic [1:0] n;
    @(negedge clk);
    cmd_a = ca; cmd_b = cb; cond = c;
    n = ref_next(ea, eb, ca, cb, c);
    @(posedge clk);
    #1;
    ea = n[1]; eb = n[0];
    check({req, " mode_a"}, mode_a, ea);
    check({req, " mode_b"}, mode_b, eb);
    check("R8 exclusive", mode_a & mode_b, 1'b0);
    check("R10 flag_both", flag_both, 1'b0);
    check("R10 flag_spurious", flag_spurious, 1'b0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 mode_a", mode_a, 1'b0);
    check("R1 mode_b", mode_b, 1'b0);
    check("R1 flags", flag_both | flag_spurious, 1'b0);
    @(negedge clk); rst = 1'b0;
    // R9: cond with no request never raises A
    step(0, 0, 1, "R9 idle");
    step(0, 0, 0, "R7 hold idle");
    // R3 then R6 changeover
    step(1, 0, 0, "R3 select A");
    step(0, 0, 0, "R7 hold A");
    step(0, 0, 1, "R6 changeover");
    // R4: A request clears B when cond low
    step(1, 0, 0, "R4 clear B");
    // R2: both commands, B wins
    step(1, 1, 1, "R2 both cmds");
    // R5 / R8 race: B active, cond high, one-cycle cmd_a, then both fall
    step(0, 0, 1, "R7 hold B");
    step(1, 0, 1, "R5 refused");
    step(0, 0, 0, "R8 race release");
    step(0, 0, 0, "R8 race settle");
    // Reset from a nonzero state
    step(1, 0, 0, "R4 to A");
    @(negedge clk); rst = 1'b1; cmd_a = 1'b1;
    @(posedge clk); #1;
    ea = 1'b0; eb = 1'b0;
    check("R1 reset dominant", mode_a, 1'b0);
    @(negedge clk); rst = 1'b0; cmd_a = 1'b0;
    // Random pulses
    for (int i = 0; i < 3000; i++) begin
      logic ca, cb, c;
      ca = ($urandom % 4) == 0;
      cb = ($urandom % 6) == 0;
      c  = ($urandom % 2) == 1;
      step(ca, cb, c, "R2-R7 random");
    end
    step(0, 0, 0, "R7 final");
    @(posedge clk); #1;
    check("R10 sticky both", flag_both, 1'b0);
    check("R10 sticky spurious", flag_spurious, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule